// File: doc/BRIEF.md
# Width Resize Buffer with Deferred Clear

This block adapts the data width between two halves of a DMA datapath whose buses differ by a power-of-two factor. It sits on the side of the transfer that has the narrower bus. Depending on a build-time direction parameter, it does one of two things. In the packing direction it gathers several narrow beats into one wide word. In the unpacking direction it splits one wide word into several narrow beats. Both sides use a valid/ready handshake.

Between handshakes the block may hold a partly assembled or partly drained word. That partial state is not cleared when the DMA is switched off, because outstanding transactions may still need the buffered data to finish. The only way to discard it is a qualified clear. That clear is raised one cycle after the source side and the destination side both report that they are quiet, and only while no transaction is pending. The clear pulse is also exported so that the surrounding logic can see when the buffer was emptied.

Top module: `wrs_resizer`

## Requirements
- R1: In the packing direction, narrow beat k of a group (k = 0 first) lands in bits [k*NARROW_W +: NARROW_W] of the wide word, so the first beat accepted is the least significant.
- R2: In the packing direction, `dn_valid` stays low until exactly RATIO narrow beats have been accepted since the last wide word or clear, and rises in the cycle after the edge that accepts the last of them.
- R3: In the packing direction, `up_ready` is low while a completed wide word waits at the output, so no narrow beat is taken until that word is consumed.
- R4: In the unpacking direction, the narrow beats of one wide word appear on `dn_data` least significant lane first, one lane per accepted output beat.
- R5: In the unpacking direction, `up_ready` stays low from the edge that accepts a wide word until the edge that consumes its final narrow beat, and is high in the cycle after that edge.
- R6: With no handshake and no clear, the partial state (lanes filled or lanes drained) is kept for any number of cycles, and a later transfer continues where it stopped.
- R7: `sync_clr` is high in the cycle after an edge at which `src_quiet` and `dst_quiet` are both high and `xfer_pending` is low, and low in the cycle after any other edge.
- R8: At an edge where `sync_clr` is high, the lane counter returns to zero and any valid output is dropped. The next group then starts at lane 0.
- R9: After reset, `dn_valid` and `sync_clr` are low and `up_ready` is high.
- R10: While `dn_valid` is high and `dn_ready` is low, `dn_valid` and `dn_data` stay unchanged until a clear occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_quiet | input | 1 | Source side reports it is ready to be cleared |
| dst_quiet | input | 1 | Destination side reports it is ready to be cleared |
| xfer_pending | input | 1 | High while any transaction is still outstanding |
| sync_clr | output | 1 | Qualified clear, registered |
| up_valid | input | 1 | Upstream data valid |
| up_ready | output | 1 | Upstream data accepted |
| up_data | input | UP_W | Upstream data: NARROW_W when packing, NARROW_W*RATIO when unpacking |
| dn_valid | output | 1 | Downstream data valid |
| dn_ready | input | 1 | Downstream ready |
| dn_data | output | DN_W | Downstream data: NARROW_W*RATIO when packing, NARROW_W when unpacking |

## Verification
A lane counter that is off by one shows at the ports in one of two ways. In the packing direction, the wide word completes one beat early or late and its bytes are rotated. In the unpacking direction, lanes come out shifted, or `up_ready` returns one beat early or late. Either shows on the first word after the fault. A missing clear shows on the first group after a sync: old lanes are mixed into the new word, or a stale beat is offered. A clear that fires spuriously shows after an idle gap: bytes from before the gap are missing from the resumed word.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

  // Direction of the width conversion performed by the resizer.
  typedef enum logic {
    WRS_PACK   = 1'b0,  // narrow beats in, wide words out
    WRS_UNPACK = 1'b1   // wide words in, narrow beats out
  } wrs_dir_e;

endpackage

// File: rtl/wrs_clear_qual.sv
module wrs_clear_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic src_quiet,
  input  logic dst_quiet,
  input  logic xfer_pending,
  output logic sync_clr
);

  logic sync_d, sync_q;

  // Both sides quiet and nothing outstanding.
  always_comb begin
    sync_d = src_quiet & dst_quiet & ~xfer_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_d;
  end

  assign sync_clr = sync_q;

  // R7: a pending transaction blocks the clear in the following cycle.
  a_r7_no_clear_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_pending |=> !sync_clr);

  // R7: one quiet side alone never produces a clear.
  a_r7_needs_both_sides: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_quiet || !dst_quiet) |=> !sync_clr);

endmodule

// File: rtl/wrs_pack.sv
module wrs_pack #(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NARROW_W-1:0]        in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NARROW_W*RATIO-1:0]  out_data
);

  localparam int WIDE_W = NARROW_W * RATIO;
  localparam int CNT_W  = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [WIDE_W-1:0] buf_q, buf_d;
  logic              buf_en;
  logic              in_fire, out_fire, last_lane;

  assign in_ready  = ~full_q;
  assign out_valid = full_q;
  assign out_data  = buf_q;
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign last_lane = (cnt_q == LAST_LANE);

  // Next-state logic.
  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    buf_d  = buf_q;
    buf_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else begin
      if (out_fire) full_d = 1'b0;
      if (in_fire) begin
        buf_en = 1'b1;
        buf_d[cnt_q*NARROW_W +: NARROW_W] = in_data;
        cnt_d = cnt_q + 1'b1;
        if (last_lane) full_d = 1'b1;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  // R2: the word becomes valid only right after the last lane is written.
  a_r2_valid_after_last_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_fire && last_lane && !clr));

  // R8: a clear empties the lane counter and drops the valid word.
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !out_valid);

  // R6: without traffic or clear, the partial state is kept.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_fire && !out_fire) |=> $stable(cnt_q) && $stable(full_q));

  // R10: a stalled wide word stays put.
  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

endmodule

// File: rtl/wrs_unpack.sv
module wrs_unpack #(
  parameter int NARROW_W = 8,
  parameter int RATIO    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NARROW_W*RATIO-1:0]  in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NARROW_W-1:0]        out_data
);

  localparam int WIDE_W = NARROW_W * RATIO;
  localparam int CNT_W  = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST_LANE = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              load_q, load_d;
  logic [WIDE_W-1:0] buf_q;
  logic              buf_en;
  logic              in_fire, out_fire, last_lane;

  assign in_ready  = ~load_q;
  assign out_valid = load_q;
  assign out_data  = buf_q[cnt_q*NARROW_W +: NARROW_W];
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign last_lane = (cnt_q == LAST_LANE);

  // Next-state logic.
  always_comb begin
    cnt_d  = cnt_q;
    load_d = load_q;
    buf_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      load_d = 1'b0;
    end else if (in_fire) begin
      buf_en = 1'b1;
      load_d = 1'b1;
      cnt_d  = '0;
    end else if (out_fire) begin
      if (last_lane) begin
        load_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= in_data;
  end

  // R5: a new wide word is taken only after the last lane drained or a clear.
  a_r5_reload_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(clr || (out_fire && last_lane)));

  // R8: a clear empties the lane counter and drops the valid beat.
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !out_valid);

  // R6: without traffic or clear, the partial state is kept.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !in_fire && !out_fire) |=> $stable(cnt_q) && $stable(load_q));

  // R10: a stalled narrow beat stays put.
  a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));

endmodule

// File: rtl/wrs_resizer.sv
module wrs_resizer
  import wrs_pkg::*;
#(
  parameter int       NARROW_W = 8,
  parameter int       RATIO    = 4,
  parameter wrs_dir_e DIR      = WRS_PACK,
  localparam int      WIDE_W   = NARROW_W * RATIO,
  localparam int      UP_W     = (DIR == WRS_PACK) ? NARROW_W : WIDE_W,
  localparam int      DN_W     = (DIR == WRS_PACK) ? WIDE_W : NARROW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_quiet,
  input  logic            dst_quiet,
  input  logic            xfer_pending,
  output logic            sync_clr,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [UP_W-1:0] up_data,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic [DN_W-1:0] dn_data
);

  // RATIO must be a power of two of at least 2.
  initial begin
    assert (RATIO >= 2 && (RATIO & (RATIO - 1)) == 0)
      else $error("wrs_resizer: RATIO must be a power of two >= 2");
  end

  logic clr;

  wrs_clear_qual u_clear (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_quiet    (src_quiet),
    .dst_quiet    (dst_quiet),
    .xfer_pending (xfer_pending),
    .sync_clr     (clr)
  );

  assign sync_clr = clr;

  generate
    if (DIR == WRS_PACK) begin : g_pack
      wrs_pack #(.NARROW_W(NARROW_W), .RATIO(RATIO)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (up_valid),
        .in_ready  (up_ready),
        .in_data   (up_data),
        .out_valid (dn_valid),
        .out_ready (dn_ready),
        .out_data  (dn_data)
      );
    end else begin : g_unpack
      wrs_unpack #(.NARROW_W(NARROW_W), .RATIO(RATIO)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .in_valid  (up_valid),
        .in_ready  (up_ready),
        .in_data   (up_data),
        .out_valid (dn_valid),
        .out_ready (dn_ready),
        .out_data  (dn_data)
      );
    end
  endgenerate

  // R9: nothing is offered downstream straight out of reset.
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dn_valid && !sync_clr);

endmodule

// File: tb/wrs_resizer_tb.sv
module wrs_resizer_tb;
  import wrs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NW    = 8;
  localparam int RATIO = 4;
  localparam int WW    = NW * RATIO;
  localparam int NVEC  = 6;
  localparam logic [WW-1:0] VEC [NVEC] = '{
    32'h03020100, 32'hDEADBEEF, 32'h00000000,
    32'hFFFFFFFF, 32'h80400201, 32'h5AA5C33C
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_quiet = 1'b0, dst_quiet = 1'b0, xfer_pending = 1'b0;

  logic          p_sync, p_in_v, p_in_r, p_out_v, p_out_r;
  logic [NW-1:0] p_in_d;
  logic [WW-1:0] p_out_d;
  logic          u_sync, u_in_v, u_in_r, u_out_v, u_out_r;
  logic [WW-1:0] u_in_d;
  logic [NW-1:0] u_out_d;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrs_resizer #(.NARROW_W(NW), .RATIO(RATIO), .DIR(WRS_PACK)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_quiet(src_quiet), .dst_quiet(dst_quiet),
    .xfer_pending(xfer_pending), .sync_clr(p_sync),
    .up_valid(p_in_v), .up_ready(p_in_r), .up_data(p_in_d),
    .dn_valid(p_out_v), .dn_ready(p_out_r), .dn_data(p_out_d)
  );

  wrs_resizer #(.NARROW_W(NW), .RATIO(RATIO), .DIR(WRS_UNPACK)) u_dut_unp (
    .clk(clk), .rst_n(rst_n), .src_quiet(src_quiet), .dst_quiet(dst_quiet),
    .xfer_pending(xfer_pending), .sync_clr(u_sync),
    .up_valid(u_in_v), .up_ready(u_in_r), .up_data(u_in_d),
    .dn_valid(u_out_v), .dn_ready(u_out_r), .dn_data(u_out_d)
  );

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Push one narrow beat into the packer; returns at the negedge after acceptance.
  task automatic p_send(input logic [NW-1:0] b);
    @(negedge clk);
    p_in_v = 1'b1;
    p_in_d = b;
    while (!p_in_r) @(negedge clk);
    @(negedge clk);
    p_in_v = 1'b0;
  endtask

  // Take one wide word from the packer.
  task automatic p_take(output logic [WW-1:0] w);
    p_out_r = 1'b1;
    while (!p_out_v) @(negedge clk);
    w = p_out_d;
    @(negedge clk);
    p_out_r = 1'b0;
  endtask

  // Push one wide word into the unpacker.
  task automatic u_send(input logic [WW-1:0] w);
    @(negedge clk);
    u_in_v = 1'b1;
    u_in_d = w;
    while (!u_in_r) @(negedge clk);
    @(negedge clk);
    u_in_v = 1'b0;
  endtask

  // Drain all lanes of w, starting at lane first, checking order and ready.
  task automatic u_drain(input logic [WW-1:0] w, input int first);
    u_out_r = 1'b1;
    for (int i = first; i < RATIO; i++) begin
      chk("R4 lane valid", {31'd0, u_out_v}, 32'd1);
      chk("R4 lane data", {24'd0, u_out_d}, {24'd0, w[i*NW +: NW]});
      chk("R5 no reload while draining", {31'd0, u_in_r}, 32'd0);
      @(negedge clk);
    end
    u_out_r = 1'b0;
    chk("R5 ready after last lane", {31'd0, u_in_r}, 32'd1);
    chk("R5 empty after last lane", {31'd0, u_out_v}, 32'd0);
  endtask

  // Raise the quiet condition for one edge; return with clears taken effect.
  task automatic pulse_sync();
    @(negedge clk);
    src_quiet = 1'b1; dst_quiet = 1'b1; xfer_pending = 1'b0;
    @(negedge clk);
    chk("R7 sync after quiet", {30'd0, p_sync, u_sync}, 32'd3);
    src_quiet = 1'b0; dst_quiet = 1'b0;
    @(negedge clk);
    chk("R7 sync drops", {30'd0, p_sync, u_sync}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [WW-1:0] w;
    p_in_v = 0; p_in_d = '0; p_out_r = 0;
    u_in_v = 0; u_in_d = '0; u_out_r = 0;

    // R9: reset state
    #1;
    chk("R9 pack reset", {28'd0, p_out_v, p_in_r, p_sync, 1'b0}, 32'h4);
    chk("R9 unpack reset", {28'd0, u_out_v, u_in_r, u_sync, 1'b0}, 32'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after release", {28'd0, p_out_v, p_in_r, u_out_v, u_in_r}, 32'h5);

    // Vector table: pack then unpack each word.
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < RATIO; k++) begin
        if (k == RATIO - 1) chk("R2 not valid before last beat", {31'd0, p_out_v}, 32'd0);
        p_send(VEC[v][k*NW +: NW]);
      end
      chk("R2 valid after last beat", {31'd0, p_out_v}, 32'd1);
      chk("R3 upstream stalled while full", {31'd0, p_in_r}, 32'd0);
      p_take(w);
      chk("R1 packed word", w, VEC[v]);
      chk("R3 upstream ready after take", {31'd0, p_in_r}, 32'd1);
      u_send(VEC[v]);
      u_drain(VEC[v], 0);
    end

    // R10: stalled wide output holds.
    for (int k = 0; k < RATIO; k++) p_send(VEC[1][k*NW +: NW]);
    repeat (3) begin
      @(negedge clk);
      chk("R10 stalled valid", {31'd0, p_out_v}, 32'd1);
      chk("R10 stalled data", p_out_d, VEC[1]);
    end
    p_take(w);
    chk("R10 word after stall", w, VEC[1]);

    // R6: partial group survives a long idle gap in both directions.
    p_send(8'h11); p_send(8'h22);
    u_send(VEC[4]);
    u_out_r = 1'b1; @(negedge clk); u_out_r = 1'b0;
    repeat (100) @(negedge clk);
    chk("R6 pack partial not valid", {31'd0, p_out_v}, 32'd0);
    chk("R6 unpack holds lane1", {24'd0, u_out_d}, {24'd0, VEC[4][NW +: NW]});
    p_send(8'h33); p_send(8'h44);
    p_take(w);
    chk("R6 resumed pack word", w, 32'h44332211);
    u_drain(VEC[4], 1);

    // R7: partial quiet conditions never clear.
    p_send(8'hA1); p_send(8'hA2);
    u_send(VEC[5]);
    u_out_r = 1'b1; @(negedge clk); u_out_r = 1'b0;
    src_quiet = 1'b1; dst_quiet = 1'b1; xfer_pending = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pending blocks clear", {31'd0, p_sync}, 32'd0);
    xfer_pending = 1'b0; dst_quiet = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 one side blocks clear", {31'd0, p_sync}, 32'd0);
    src_quiet = 1'b0;
    chk("R7 unpack kept lane1", {24'd0, u_out_d}, {24'd0, VEC[5][NW +: NW]});

    // R8: qualified clear empties both directions.
    pulse_sync();
    chk("R8 pack cleared ready", {31'd0, p_in_r}, 32'd1);
    chk("R8 unpack cleared valid", {31'd0, u_out_v}, 32'd0);
    chk("R8 unpack cleared ready", {31'd0, u_in_r}, 32'd1);
    for (int k = 0; k < RATIO; k++) p_send(VEC[2][k*NW +: NW] ^ 8'h5C);
    p_take(w);
    chk("R8 fresh pack group", w, VEC[2] ^ 32'h5C5C5C5C);
    u_send(VEC[3] ^ 32'h01234567);
    u_drain(VEC[3] ^ 32'h01234567, 0);

    report();
    $finish;
  end

endmodule